// File: doc/BRIEF.md
# Keyed SDRAM Command Port

This block gives a host processor a small register window for issuing single SDRAM commands, such as precharge, refresh, mode-register load or a single read or write. These commands bypass the normal system-bus path. The host first loads a target address register. For commands that carry a payload, it also loads a transmit data register. It then writes the command register.

A command write has effect only when its upper half holds a fixed unlock key. An accepted command becomes exactly one request to a downstream SDRAM command generator, over a valid/ready handshake. The port then stays busy until the generator reports completion. Read results land in a receive register. Completion and failure show up as two sticky status flags, which are cleared by writing 1 to them.

Rejected writes issue nothing and raise the error flag. A write is rejected if it has a wrong key, if it carries a code outside the port's code space, or if it arrives while a command is still in flight.

Top module: `sdram_ipcmd_port`

## Requirements
- R1: After reset, `busy_o` and `req_valid_o` are low, and every register reads back as zero.
- R2: The address register (offset 0) and the transmit data register (offset 1) read back the last value written to them.
- R3: A write to the command register (offset 2) is accepted only when bits [31:16] equal 0xA55A. Any other key sets the error flag and issues no request.
- R4: The command code sits in bits [3:0]. The accepted codes are 0x8 read, 0x9 write, 0xA mode-register set, 0xB activate, 0xC auto refresh, 0xD self refresh, 0xE precharge and 0xF precharge all. Codes 0x0 to 0x7, including the system-bus codes 0x0 and 0x1, set the error flag and issue nothing.
- R5: In the cycle after an accepted command write, `req_valid_o` and `busy_o` are high, and `req_code_o` carries the code.
- R6: `req_wdata_o` carries the transmit register only for codes 0x9 and 0xA. For every other code it is zero.
- R7: `req_valid_o` and the request fields stay stable until `req_ready_i` is high. Exactly one handshake occurs per accepted command.
- R8: A command write while busy sets the error flag, issues no second request, and leaves the command in flight unaffected.
- R9: While waiting after the handshake, `rsp_valid_i` ends the command: `busy_o` falls on the next cycle. Status bit 0 (done) is set when `rsp_err_i` is low; status bit 1 (error) is set when `rsp_err_i` is high.
- R10: When a read (0x8) completes, `rsp_rdata_i` is stored in the receive register (offset 4). No other command alters that register.
- R11: Writing 1 to a status bit (offset 3) clears it. An accepted command clears both bits.
- R12: The address is sampled when the command is accepted, for every command. Later writes to the address register do not change `req_addr_o` of the command in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_ofs_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the register at `reg_ofs_i` |
| busy_o | output | 1 | A command is in flight |
| req_valid_o | output | 1 | Downstream request valid |
| req_ready_i | input | 1 | Downstream accepts the request |
| req_code_o | output | 4 | Command code of the request |
| req_addr_o | output | ADDR_W | Target address sampled at acceptance |
| req_wdata_o | output | DATA_W | Payload for write and mode-register set |
| rsp_valid_i | input | 1 | Downstream reports completion |
| rsp_err_i | input | 1 | Completion carries a failure |
| rsp_rdata_i | input | DATA_W | Data returned by a read |

## Verification
The hardest case to reach is a command write that arrives while a command is in flight. It has to land between acceptance and completion without disturbing the request that is already stalled on the handshake. The bench holds `req_ready_i` low for a chosen number of cycles and writes the command register again inside that window. In another run, it rewrites the address register inside the same window. The scoreboard then confirms that only the original request, with its original address, crosses the handshake, and that the error flag is set while the later completion still sets done.

// File: rtl/ipcmd_pkg.sv
package ipcmd_pkg;
  localparam int BUS_W = 32;
  localparam int OFS_W = 3;
  localparam int CODE_W = 4;
  localparam logic [15:0] UNLOCK_KEY = 16'hA55A;

  typedef enum logic [OFS_W-1:0] {
    OFS_ADDR = 3'd0,
    OFS_TXD  = 3'd1,
    OFS_CMD  = 3'd2,
    OFS_STAT = 3'd3,
    OFS_RXD  = 3'd4
  } reg_ofs_e;

  typedef enum logic [CODE_W-1:0] {
    C_RD   = 4'h8,
    C_WR   = 4'h9,
    C_MRS  = 4'hA,
    C_ACT  = 4'hB,
    C_AREF = 4'hC,
    C_SREF = 4'hD,
    C_PRE  = 4'hE,
    C_PREA = 4'hF
  } cmd_e;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;
endpackage

// File: rtl/ipcmd_decode.sv
module ipcmd_decode
  import ipcmd_pkg::*;
(
  input  logic [BUS_W-1:0]  wdata_i,
  output logic              key_ok_o,
  output logic              code_ok_o,
  output logic [CODE_W-1:0] code_o,
  output logic              payload_o
);
  assign code_o    = wdata_i[CODE_W-1:0];
  assign key_ok_o  = (wdata_i[BUS_W-1:BUS_W-16] == UNLOCK_KEY);
  // only the upper half of the code space is issuable here
  assign code_ok_o = code_o[CODE_W-1];
  assign payload_o = (code_o == C_WR) || (code_o == C_MRS);
endmodule

// File: rtl/ipcmd_regs.sv
module ipcmd_regs
  import ipcmd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              accept_i,
  input  logic              payload_i,
  input  logic              rx_load_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] txd_o,
  output logic [DATA_W-1:0] rxd_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o      <= '0;
      txd_o       <= '0;
      rxd_o       <= '0;
      req_addr_o  <= '0;
      req_wdata_o <= '0;
    end else begin
      if (wr_i && ofs_i == OFS_ADDR) addr_o <= wdata_i[ADDR_W-1:0];
      if (wr_i && ofs_i == OFS_TXD)  txd_o  <= wdata_i[DATA_W-1:0];
      if (rx_load_i) rxd_o <= rx_data_i;
      if (accept_i) begin
        req_addr_o  <= addr_o;
        req_wdata_o <= payload_i ? txd_o : '0;
      end
    end
  end
endmodule

// File: rtl/ipcmd_seq.sv
module ipcmd_seq
  import ipcmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic              key_ok_i,
  input  logic              code_ok_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              stat_wr_i,
  input  logic [1:0]        stat_w1c_i,
  input  logic              req_ready_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  output logic              accept_o,
  output logic              rx_load_o,
  output logic              busy_o,
  output logic              req_valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o,
  output logic              err_o
);
  st_e st_q, st_d;
  logic reject, complete;

  assign accept_o  = cmd_wr_i && key_ok_i && code_ok_i && (st_q == S_IDLE);
  assign reject    = cmd_wr_i && !accept_o;
  assign complete  = (st_q == S_WAIT) && rsp_valid_i;
  assign rx_load_o = complete && (code_o == C_RD);
  assign busy_o      = (st_q != S_IDLE);
  assign req_valid_o = (st_q == S_REQ);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (accept_o) st_d = S_REQ;
      S_REQ:   if (req_ready_i) st_d = S_WAIT;
      S_WAIT:  if (rsp_valid_i) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      code_o <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept_o) code_o <= code_i;
      // set has priority over write-1-to-clear
      if (accept_o)                  done_o <= 1'b0;
      else if (complete && !rsp_err_i) done_o <= 1'b1;
      else if (stat_wr_i && stat_w1c_i[0]) done_o <= 1'b0;
      if (accept_o)                  err_o <= 1'b0;
      else if (reject || (complete && rsp_err_i)) err_o <= 1'b1;
      else if (stat_wr_i && stat_w1c_i[1]) err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_ipcmd_port.sv
module sdram_ipcmd_port
  import ipcmd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_ofs_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              busy_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [3:0]        req_code_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  input  logic [DATA_W-1:0] rsp_rdata_i
);
  logic key_ok, code_ok, payload, accept, rx_load, done_w, err_w;
  logic [CODE_W-1:0] dec_code;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] txd_q, rxd_q;
  logic cmd_wr, stat_wr;

  assign cmd_wr  = reg_wr_i && (reg_ofs_i == OFS_CMD);
  assign stat_wr = reg_wr_i && (reg_ofs_i == OFS_STAT);

  ipcmd_decode u_dec (
    .wdata_i  (reg_wdata_i),
    .key_ok_o (key_ok),
    .code_ok_o(code_ok),
    .code_o   (dec_code),
    .payload_o(payload)
  );

  ipcmd_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (cmd_wr),
    .key_ok_i   (key_ok),
    .code_ok_i  (code_ok),
    .code_i     (dec_code),
    .stat_wr_i  (stat_wr),
    .stat_w1c_i (reg_wdata_i[1:0]),
    .req_ready_i(req_ready_i),
    .rsp_valid_i(rsp_valid_i),
    .rsp_err_i  (rsp_err_i),
    .accept_o   (accept),
    .rx_load_o  (rx_load),
    .busy_o     (busy_o),
    .req_valid_o(req_valid_o),
    .code_o     (req_code_o),
    .done_o     (done_w),
    .err_o      (err_w)
  );

  ipcmd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .ofs_i      (reg_ofs_i),
    .wdata_i    (reg_wdata_i),
    .accept_i   (accept),
    .payload_i  (payload),
    .rx_load_i  (rx_load),
    .rx_data_i  (rsp_rdata_i),
    .addr_o     (addr_q),
    .txd_o      (txd_q),
    .rxd_o      (rxd_q),
    .req_addr_o (req_addr_o),
    .req_wdata_o(req_wdata_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_ofs_i)
      OFS_ADDR: reg_rdata_o = BUS_W'(addr_q);
      OFS_TXD:  reg_rdata_o = BUS_W'(txd_q);
      OFS_CMD:  reg_rdata_o = BUS_W'(req_code_o);
      OFS_STAT: reg_rdata_o = {30'd0, err_w, done_w};
      OFS_RXD:  reg_rdata_o = BUS_W'(rxd_q);
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ipcmd_chk.sv
module ipcmd_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [2:0]        reg_ofs_i,
  input logic [31:0]       reg_wdata_i,
  input logic              busy_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [3:0]        req_code_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [DATA_W-1:0] req_wdata_o,
  input logic              rsp_valid_i,
  input logic              done_w,
  input logic              err_w
);
  logic cmd_wr;
  assign cmd_wr = reg_wr_i && (reg_ofs_i == 3'd2);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_code_o)
      && $stable(req_addr_o) && $stable(req_wdata_o));

  p_code_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_code_o[3]);

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o);

  p_bad_key_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && !busy_o && reg_wdata_i[31:16] != 16'hA55A |=> err_w && !req_valid_o);

  p_busy_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && busy_o |=> err_w);

  p_accept_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && !busy_o && reg_wdata_i[31:16] == 16'hA55A && reg_wdata_i[3]
      |=> req_valid_o && !done_w && !err_w);

  p_complete_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !req_valid_o && rsp_valid_i |=> !busy_o && (done_w || err_w));
endmodule

bind sdram_ipcmd_port ipcmd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_ofs_i  (reg_ofs_i),
  .reg_wdata_i(reg_wdata_i),
  .busy_o     (busy_o),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_code_o (req_code_o),
  .req_addr_o (req_addr_o),
  .req_wdata_o(req_wdata_o),
  .rsp_valid_i(rsp_valid_i),
  .done_w     (done_w),
  .err_w      (err_w)
);

// File: tb/sdram_ipcmd_port_tb_top.sv
module sdram_ipcmd_port_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_wr_i = 1'b0;
  logic [2:0] reg_ofs_i = 3'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic busy_o, req_valid_o;
  logic req_ready_i = 1'b0;
  logic [3:0] req_code_o;
  logic [31:0] req_addr_o, req_wdata_o;
  logic rsp_valid_i = 1'b0;
  logic rsp_err_i = 1'b0;
  logic [31:0] rsp_rdata_i = '0;

  always #5 clk_i = ~clk_i;

  sdram_ipcmd_port dut_i (.*);

  typedef struct packed {
    logic [3:0]  code;
    logic [31:0] addr;
    logic [31:0] wd;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every handshake must match the next expected request (R5 R6 R7 R12)
  always @(posedge clk_i) begin
    if (rst_ni && req_valid_o && req_ready_i) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected request", {28'd0, req_code_o, req_addr_o}, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(req_code_o == e.code, "R5 code", 64'(req_code_o), 64'(e.code));
        check(req_addr_o == e.addr, "R12 addr", 64'(req_addr_o), 64'(e.addr));
        check(req_wdata_o == e.wd, "R6 wdata", 64'(req_wdata_o), 64'(e.wd));
      end
    end
  end

  task automatic write_reg(input logic [2:0] ofs, input logic [31:0] d);
    reg_wr_i = 1'b1; reg_ofs_i = ofs; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] ofs, output logic [31:0] d);
    reg_ofs_i = ofs;
    #1 d = reg_rdata_o;
  endtask

  task automatic run_cmd(input logic [3:0] code, input logic [31:0] a, input logic [31:0] tx,
                         input int wait_n, input bit err_rsp, input logic [31:0] rd,
                         input bit poke_busy, input bit poke_addr);
    exp_t e;
    logic [31:0] v;
    write_reg(3'd0, a);
    write_reg(3'd1, tx);
    e.code = code; e.addr = a;
    e.wd = (code == 4'h9 || code == 4'hA) ? tx : 32'd0;
    sb_q.push_back(e);
    write_reg(3'd2, {16'hA55A, 12'd0, code});
    check(busy_o && req_valid_o, "R5 busy after accept", {busy_o, req_valid_o}, 2'b11);
    read_reg(3'd3, v);
    check(v == 0, "R11 accept clears status", v, 0);
    if (poke_addr) write_reg(3'd0, a ^ 32'hFFFF_0000);
    if (poke_busy) begin
      write_reg(3'd2, {16'hA55A, 12'd0, 4'hC});
      read_reg(3'd3, v);
      check(v[1] && req_valid_o, "R8 busy write rejected", v, 2);
    end
    repeat (wait_n) @(negedge clk_i);
    check(req_valid_o, "R7 valid held", req_valid_o, 1);
    req_ready_i = 1'b1;
    @(negedge clk_i);
    req_ready_i = 1'b0;
    check(!req_valid_o && busy_o, "R7 single handshake", {req_valid_o, busy_o}, 2'b01);
    rsp_valid_i = 1'b1; rsp_err_i = err_rsp; rsp_rdata_i = rd;
    @(negedge clk_i);
    rsp_valid_i = 1'b0; rsp_err_i = 1'b0;
    check(!busy_o, "R9 busy released", busy_o, 0);
    read_reg(3'd3, v);
    check(v == {30'd0, err_rsp | poke_busy, !err_rsp}, "R9 status", v,
          {30'd0, err_rsp | poke_busy, !err_rsp});
  endtask

  task automatic bad_cmd(input logic [31:0] d, input string req);
    logic [31:0] v;
    write_reg(3'd3, 32'h3);
    write_reg(3'd2, d);
    check(!busy_o && !req_valid_o, req, {busy_o, req_valid_o}, 0);
    read_reg(3'd3, v);
    check(v == 32'h2, req, v, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check(!busy_o && !req_valid_o, "R1 idle", {busy_o, req_valid_o}, 0);
    for (int o = 0; o < 5; o++) begin
      read_reg(3'(o), v);
      check(v == 0, "R1 reset reg", v, 0);
    end
    // R2
    write_reg(3'd0, 32'h1234_5678);
    write_reg(3'd1, 32'hCAFE_F00D);
    read_reg(3'd0, v); check(v == 32'h1234_5678, "R2 addr readback", v, 32'h1234_5678);
    read_reg(3'd1, v); check(v == 32'hCAFE_F00D, "R2 txd readback", v, 32'hCAFE_F00D);
    // R5 R6 R7 R9: activate with stall
    run_cmd(4'hB, 32'h8000_0100, 32'h1111_2222, 3, 0, 32'h0, 0, 0);
    // R6 payload commands
    run_cmd(4'h9, 32'h8000_0200, 32'hDEAD_BEEF, 0, 0, 32'h0, 0, 0);
    run_cmd(4'hA, 32'h8000_0000, 32'h0000_0033, 1, 0, 32'h0, 0, 0);
    // R10 read captures
    run_cmd(4'h8, 32'h8000_0400, 32'h5555_5555, 2, 0, 32'hA1B2_C3D4, 0, 0);
    read_reg(3'd4, v); check(v == 32'hA1B2_C3D4, "R10 rx captured", v, 32'hA1B2_C3D4);
    run_cmd(4'hE, 32'h8000_0400, 32'h0, 0, 0, 32'h0BAD_0BAD, 0, 0);
    read_reg(3'd4, v); check(v == 32'hA1B2_C3D4, "R10 rx unchanged", v, 32'hA1B2_C3D4);
    // R3 wrong keys
    bad_cmd({16'hA55B, 12'd0, 4'hB}, "R3 wrong key");
    bad_cmd({16'h0000, 12'd0, 4'h8}, "R3 zero key");
    // R11 w1c
    write_reg(3'd3, 32'h2);
    read_reg(3'd3, v); check(v == 0, "R11 w1c error", v, 0);
    // R4 reserved codes
    bad_cmd({16'hA55A, 12'd0, 4'h0}, "R4 code 0x0");
    bad_cmd({16'hA55A, 12'd0, 4'h1}, "R4 code 0x1");
    bad_cmd({16'hA55A, 12'd0, 4'h7}, "R4 code 0x7");
    // R8 write while busy, R11 next accept clears both
    run_cmd(4'hF, 32'h8000_0800, 32'h0, 2, 0, 32'h0, 1, 0);
    run_cmd(4'hC, 32'h8000_0800, 32'h0, 0, 0, 32'h0, 0, 0);
    // R9 error completion
    run_cmd(4'hD, 32'h8000_0000, 32'h0, 1, 1, 32'h0, 0, 0);
    write_reg(3'd3, 32'h1);
    read_reg(3'd3, v); check(v == 32'h2, "R11 w1c done only", v, 2);
    // R12 address change while in flight
    run_cmd(4'hB, 32'h8001_2340, 32'h0, 2, 0, 32'h0, 0, 1);
    // R4 every legal code
    for (int c = 8; c < 16; c++)
      run_cmd(4'(c), 32'h9000_0000 + 32'(c), 32'h7700_0000 + 32'(c), c % 3, 0, 32'h0, 0, 0);
    repeat (2) @(negedge clk_i);
    check(sb_q.size() == 0, "R7 all requests seen", sb_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule